// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block turns a fast core clock into the SCL waveform of an I2C master. It also produces two one-cycle timing strobes in every SCL period. A programmable divider sets the period. The drive strobe lands a programmed number of core clocks into the low phase and tells the shifter when to put the next bit on SDA. The sample strobe lands a programmed number of core clocks into the high phase and tells the shifter when to capture SDA.

The divider word is always read as an even number, because its least significant bit is dropped. Half of the even period is spent with SCL pulled low and the other half with SCL released. The two delay values share one 32-bit configuration word: the falling-edge delay sits in bits 31:16 and the rising-edge delay sits in bits 15:0. Each delay is forced into the range 1 to DIV/2, so that each strobe fires exactly once per period. While the enable is low, SCL stays released and the period counter holds at its start. Detection of a stretched clock belongs to a separate timeout block and is not part of this one.

A three-state machine controls the block:
- **IDLE** leaves SCL released.
- **LOW** pulls SCL low.
- **HIGH** releases SCL.

Its transitions are:
- **START**: IDLE to LOW when the enable is high.
- **RISE**: LOW to HIGH after the last low cycle.
- **FALL**: HIGH to LOW after the last high cycle.
- **STOP**: from any state to IDLE when the enable is low.

Top module: `scl_timegen`

## Requirements
- R1: While reset is active or the enable is low, `scl_low_req`, `drive_stb` and `sample_stb` are all 0.
- R2: The core clock edge that first samples the enable high starts a period. Counting that cycle as k=0, `scl_low_req` is 1 for positions 0..h-1 of each 2h-cycle period and 0 for positions h..2h-1. Here h = div_cfg[15:1].
- R3: The divider LSB is ignored, so an odd divider behaves like the even value below it. A divider of 0 or 1 behaves like 2 (h=1).
- R4: `drive_stb` is 1 for exactly one cycle per period, at period position fe-1. Here fe is the falling-edge delay taken from dly_cfg[31:16] after clamping.
- R5: `sample_stb` is 1 for exactly one cycle per period, at period position h+re-1. Here re is the rising-edge delay taken from dly_cfg[15:0] after clamping.
- R6: A delay field of 0 behaves as 1.
- R7: A delay field greater than h behaves as h, which puts its strobe in the last cycle of its phase.
- R8: When the enable drops, all outputs are 0 from the next cycle on. A later enable restarts the period from position 0, whatever phase was interrupted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the SCL generator while high |
| div_cfg | input | 16 | SCL period in core clocks; the LSB is ignored |
| dly_cfg | input | 32 | Falling-edge delay in [31:16], rising-edge delay in [15:0] |
| scl_low_req | output | 1 | 1 requests that SCL be pulled low |
| drive_stb | output | 1 | One-cycle strobe to drive the next SDA bit |
| sample_stb | output | 1 | One-cycle strobe to sample SDA |

## Verification
The bench targets the smallest dividers (0, 1, 2 and 3). At these values a design that kept the LSB, or that allowed a zero half period, would stretch the period or stall in one phase. It also programs delays of zero and delays larger than DIV/2. An unclamped design would then drop a strobe or move it into the wrong phase. Enable is dropped part-way through a low phase and part-way through a high phase, which exposes a counter that resumes instead of restarting and leaves SCL stuck low. Random dividers and delays are compared, cycle by cycle, against a positional model computed in the bench.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;
endpackage

// File: rtl/scl_tg_cfg.sv
// Decodes divider and delay words into a half period and two clamped delays.
module scl_tg_cfg #(
    parameter int DIV_W = 16,
    parameter int DLY_W = 16
) (
    input  logic [DIV_W-1:0]   div_cfg,
    input  logic [2*DLY_W-1:0] dly_cfg,
    output logic [DIV_W-2:0]   half_o,
    output logic [DIV_W-2:0]   fall_dly_o,
    output logic [DIV_W-2:0]   rise_dly_o
);
    localparam int HALF_W = DIV_W - 1;
    localparam int CW     = (DLY_W > HALF_W) ? DLY_W : HALF_W;

    logic [HALF_W-1:0] half_raw;
    logic [HALF_W-1:0] lane_out [2];

    always_comb begin
        half_raw = div_cfg[DIV_W-1:1];
        if (half_raw == '0) begin
            half_o = {{(HALF_W-1){1'b0}}, 1'b1};
        end else begin
            half_o = half_raw;
        end
    end

    // Lane 1 holds the falling-edge delay, lane 0 the rising-edge delay.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [CW-1:0] raw_w;
        logic [CW-1:0] lim_w;
        logic [CW-1:0] eff_w;
        always_comb begin
            raw_w = CW'(dly_cfg[g*DLY_W +: DLY_W]);
            lim_w = CW'(half_o);
            if (raw_w == '0) begin
                eff_w = {{(CW-1){1'b0}}, 1'b1};
            end else if (raw_w > lim_w) begin
                eff_w = lim_w;
            end else begin
                eff_w = raw_w;
            end
            lane_out[g] = eff_w[HALF_W-1:0];
        end
    end

    assign fall_dly_o = lane_out[1];
    assign rise_dly_o = lane_out[0];
endmodule

// File: rtl/scl_tg_fsm.sv
// Phase state machine with the within-phase cycle counter.
module scl_tg_fsm
    import scl_tg_pkg::*;
#(
    parameter int HALF_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [HALF_W-1:0] half,
    output phase_e            state_o,
    output logic [HALF_W-1:0] pcnt_o
);
    phase_e            state_q, state_d;
    logic [HALF_W-1:0] pcnt_q, pcnt_d;
    logic              last_cyc;

    assign last_cyc = (pcnt_q == half - {{(HALF_W-1){1'b0}}, 1'b1});

    always_comb begin
        state_d = state_q;
        pcnt_d  = pcnt_q + {{(HALF_W-1){1'b0}}, 1'b1};
        if (!enable) begin
            state_d = PH_IDLE;                 // STOP
            pcnt_d  = '0;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    state_d = PH_LOW;          // START
                    pcnt_d  = '0;
                end
                PH_LOW: begin
                    if (last_cyc) begin
                        state_d = PH_HIGH;     // RISE
                        pcnt_d  = '0;
                    end
                end
                PH_HIGH: begin
                    if (last_cyc) begin
                        state_d = PH_LOW;      // FALL
                        pcnt_d  = '0;
                    end
                end
                default: begin
                    state_d = PH_IDLE;
                    pcnt_d  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            pcnt_q  <= pcnt_d;
        end
    end

    assign state_o = state_q;
    assign pcnt_o  = pcnt_q;
endmodule

// File: rtl/scl_tg_strobe.sv
// Output decode: SCL request and the two phase-relative strobes.
module scl_tg_strobe
    import scl_tg_pkg::*;
#(
    parameter int HALF_W = 15
) (
    input  phase_e            state,
    input  logic [HALF_W-1:0] pcnt,
    input  logic [HALF_W-1:0] fall_dly,
    input  logic [HALF_W-1:0] rise_dly,
    output logic              scl_low_req,
    output logic              drive_stb,
    output logic              sample_stb
);
    logic [HALF_W:0] ord;   // 1-based cycle number within the phase

    always_comb begin
        ord         = {1'b0, pcnt} + {{HALF_W{1'b0}}, 1'b1};
        scl_low_req = 1'b0;
        drive_stb   = 1'b0;
        sample_stb  = 1'b0;
        unique case (state)
            PH_IDLE: ;
            PH_LOW: begin
                scl_low_req = 1'b1;
                drive_stb   = (ord == {1'b0, fall_dly});
            end
            PH_HIGH: begin
                sample_stb  = (ord == {1'b0, rise_dly});
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/scl_timegen.sv
module scl_timegen
    import scl_tg_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int DLY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [DIV_W-1:0]   div_cfg,
    input  logic [2*DLY_W-1:0] dly_cfg,
    output logic               scl_low_req,
    output logic               drive_stb,
    output logic               sample_stb
);
    localparam int HALF_W = DIV_W - 1;

    logic [HALF_W-1:0] half_eff;
    logic [HALF_W-1:0] fall_dly;
    logic [HALF_W-1:0] rise_dly;
    logic [HALF_W-1:0] pcnt_q;
    phase_e            state_q;

    scl_tg_cfg #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_cfg (
        .div_cfg    (div_cfg),
        .dly_cfg    (dly_cfg),
        .half_o     (half_eff),
        .fall_dly_o (fall_dly),
        .rise_dly_o (rise_dly)
    );

    scl_tg_fsm #(.HALF_W(HALF_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .half    (half_eff),
        .state_o (state_q),
        .pcnt_o  (pcnt_q)
    );

    scl_tg_strobe #(.HALF_W(HALF_W)) u_stb (
        .state       (state_q),
        .pcnt        (pcnt_q),
        .fall_dly    (fall_dly),
        .rise_dly    (rise_dly),
        .scl_low_req (scl_low_req),
        .drive_stb   (drive_stb),
        .sample_stb  (sample_stb)
    );
endmodule

// File: rtl/scl_timegen_chk.sv
module scl_timegen_chk
    import scl_tg_pkg::*;
#(
    parameter int HALF_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              scl_low_req,
    input logic              drive_stb,
    input logic              sample_stb,
    input phase_e            state_q,
    input logic [HALF_W-1:0] pcnt_q,
    input logic [HALF_W-1:0] half_eff
);
    p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_low_req && !drive_stb && !sample_stb));

    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == PH_IDLE) |=> scl_low_req);

    p_phase_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PH_IDLE) |-> (pcnt_q < half_eff));

    p_drive_in_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drive_stb |-> scl_low_req);

    p_sample_in_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (!scl_low_req && state_q == PH_HIGH));

    p_strobes_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({drive_stb, sample_stb}) <= 1);

    p_no_double_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drive_stb |=> !drive_stb);
endmodule

bind scl_timegen scl_timegen_chk #(.HALF_W(DIV_W-1)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .scl_low_req (scl_low_req),
    .drive_stb   (drive_stb),
    .sample_stb  (sample_stb),
    .state_q     (state_q),
    .pcnt_q      (pcnt_q),
    .half_eff    (half_eff)
);

// File: tb/sim_scl_timegen.sv
`timescale 1ns/1ps
module sim_scl_timegen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] div_cfg = 16'd4;
    logic [31:0] dly_cfg = 32'h0001_0001;
    logic        scl_low_req, drive_stb, sample_stb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    scl_timegen u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .div_cfg(div_cfg), .dly_cfg(dly_cfg),
        .scl_low_req(scl_low_req), .drive_stb(drive_stb), .sample_stb(sample_stb)
    );

    function automatic int exp_half(input int d);
        int h;
        h = d / 2;
        if (h == 0) h = 1;
        return h;
    endfunction

    function automatic int exp_dly(input int raw, input int h);
        if (raw == 0) return 1;
        if (raw > h) return h;
        return raw;
    endfunction

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    // tag names the requirement the trial's configuration targets
    task automatic trial(input int d, input int fe_raw, input int re_raw,
                         input int ncyc, input string tag);
        int h, fe, re, p;
        @(negedge clk);
        enable  = 1'b0;
        div_cfg = d[15:0];
        dly_cfg = {fe_raw[15:0], re_raw[15:0]};
        @(negedge clk);
        enable = 1'b1;
        h  = exp_half(d);
        fe = exp_dly(fe_raw, h);
        re = exp_dly(re_raw, h);
        p  = 2 * h;
        @(posedge clk);
        for (int k = 0; k < ncyc; k++) begin
            int pos;
            @(negedge clk);
            pos = k % p;
            chk({"R2 ", tag}, "scl_low_req", int'(scl_low_req), int'(pos < h));
            chk({"R4 ", tag}, "drive_stb",   int'(drive_stb),   int'(pos == fe - 1));
            chk({"R5 ", tag}, "sample_stb",  int'(sample_stb),  int'(pos == h + re - 1));
        end
        enable = 1'b0;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk("R8", "outputs after disable",
                int'({scl_low_req, drive_stb, sample_stb}), 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        enable = 1'b1;   // held high in reset: must stay quiet (R1)
        repeat (3) begin
            @(negedge clk);
            chk("R1", "outputs in reset", int'({scl_low_req, drive_stb, sample_stb}), 0);
        end
        @(negedge clk);
        enable = 1'b0;
        rst_n  = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R1", "outputs disabled", int'({scl_low_req, drive_stb, sample_stb}), 0);
        end

        trial(8,  2, 3, 20, "base");
        trial(2,  1, 1, 9,  "R3 div2");
        trial(3,  1, 1, 9,  "R3 odd div3");
        trial(0,  5, 5, 9,  "R3 div0 R7");
        trial(1,  0, 0, 9,  "R3 div1 R6");
        trial(11, 7, 4, 25, "R3 odd div11");
        trial(10, 0, 0, 24, "R6 zero delays");
        trial(12, 40, 6, 28, "R7 fedl clamp");
        trial(12, 6, 999, 28, "R7 redl clamp");
        trial(20, 3, 3, 4,  "R8 stop in low");
        trial(20, 3, 3, 14, "R8 stop in high");
        trial(20, 3, 3, 44, "R8 restart");

        for (int t = 0; t < 24; t++) begin
            int d, h;
            d = int'($urandom_range(0, 120));
            h = exp_half(d);
            trial(d, int'($urandom_range(0, 70)), int'($urandom_range(0, 70)),
                  2 * 2 * h + 3, "random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired, got running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule